// File: doc/BRIEF.md
# Tempo-Tracking Digital Phase-Locked Loop

This block regenerates a local tempo clock that follows an incoming stream of single-cycle timing strobes, for example one strobe per 24th of a quarter note. The block locks to that stream in both frequency and phase. A three-state lead/lag detector sees each incoming reference strobe and each local pulse. A fixed-rate update tick, derived inside the block from the system clock, adds the detector state to a saturating signed accumulator. The accumulator then scales the period of a tick-counting local oscillator.

The local period, in update ticks, is the nominal period plus the gain times the accumulator. It is clamped between two bounds set at the ports. The block therefore holds lock at the pulse level and does not try to align to beats. The nominal period for 120 BPM at 24 pulses per quarter note is the tick rate divided by 48. With the default tick prescaler and a 48 kHz tick, this is 1000 ticks.

Top module: `tempo_dpll`

## Requirements
- R1: `lag_state` shows the detector state as a 2-bit two's-complement value, and only three codes ever appear: 2'b11 (-1, accumulator falling), 2'b00 (0, hold), 2'b01 (+1, accumulator rising).
- R2: A reference strobe in a cycle with no local pulse moves the state one step toward -1 at the next clock edge: +1 becomes 0, 0 becomes -1, and -1 stays -1.
- R3: A local pulse in a cycle with no reference strobe moves the state one step toward +1 at the next edge: -1 becomes 0, 0 becomes +1, and +1 stays +1.
- R4: When a reference strobe and a local pulse fall in the same cycle, they cancel and the state is left unchanged.
- R5: The update tick fires once every TICK_DIV clocks. On a tick the state value is added to the accumulator, and between ticks `acc_out` does not change.
- R6: The accumulator is a signed ACC_W-bit value. It saturates at its most positive and most negative values instead of wrapping.
- R7: The local period in ticks is nominal + floor(acc × gain / 2^GAIN_FRAC), with `gain` unsigned. The result is clamped to [lo, hi], where lo = max(min_period, 1) and hi = max(max_period, lo). `loc_pulse` is a one-cycle pulse issued at the tick on which the tick count since the previous pulse reaches the current period.
- R8: While `rst_n` is low at a clock edge, the state returns to 0, the accumulator to 0, the tick phase and oscillator count to 0, and `loc_pulse` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| ref_stb | input | 1 | one-cycle reference timing strobe |
| gain | input | GAIN_W | unsigned loop gain, GAIN_FRAC fraction bits |
| nom_period | input | PER_W | nominal local period in update ticks |
| min_period | input | PER_W | lower period bound (0 treated as 1) |
| max_period | input | PER_W | upper period bound |
| loc_pulse | output | 1 | one-cycle regenerated tempo pulse |
| acc_out | output | ACC_W | signed loop accumulator |
| lag_state | output | 2 | lead/lag state, two's complement |

## Verification
The assertions assume that `ref_stb` is a single-cycle strobe. Back-to-back strobes are still legal, because every detector rule is checked cycle by cycle. They also assume that the configuration inputs change only between clock edges. The bench drives every input at falling edges, so this holds throughout. It keeps min_period ≤ max_period in the random phase, so clamping is exercised only on the meaningful side of each bound. It uses a short accumulator so that both saturation limits are reached within the run.

// File: rtl/tdpll_pkg.sv
// Package: shared lead/lag state type and its three legal codes.
// Assumes two's-complement interpretation of the 2-bit state.
package tdpll_pkg;

    typedef logic signed [1:0] lag_t;

    localparam lag_t LAG_DN   = 2'sb11;
    localparam lag_t LAG_HOLD = 2'sb00;
    localparam lag_t LAG_UP   = 2'sb01;

endpackage

// File: rtl/tdpll_tick.sv
// Module: fixed-rate update tick prescaler.
// Emits a one-cycle tick every TICK_DIV clocks; the first tick follows
// TICK_DIV edges after reset. Assumes TICK_DIV >= 1.
module tdpll_tick #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);

    logic [CW-1:0] phase;

    // Count clocks and raise the tick when the phase wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            tick  <= 1'b0;
        end else if (phase == TOP) begin
            phase <= '0;
            tick  <= 1'b1;
        end else begin
            phase <= phase + 1'b1;
            tick  <= 1'b0;
        end
    end

    // Two ticks are never adjacent unless the divider is 1.
    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (TICK_DIV > 1 && tick) |=> !tick);

endmodule

// File: rtl/tdpll_detect.sv
// Module: three-state lead/lag detector.
// A reference event steps the state toward -1, a local event toward +1,
// and coincident events cancel. Assumes both events are one-cycle strobes.
module tdpll_detect
    import tdpll_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_evt,
    input  logic loc_evt,
    output lag_t state
);

    // Step the state one level per unmatched event, saturating at +/-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LAG_HOLD;
        end else if (ref_evt && !loc_evt) begin
            state <= (state == LAG_UP) ? LAG_HOLD : LAG_DN;
        end else if (loc_evt && !ref_evt) begin
            state <= (state == LAG_DN) ? LAG_HOLD : LAG_UP;
        end
    end

    p_legal_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state != 2'b10);

    p_ref_from_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_evt && !loc_evt && state == LAG_UP) |=> state == LAG_HOLD);

    p_ref_else_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_evt && !loc_evt && state != LAG_UP) |=> state == LAG_DN);

    p_loc_from_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_evt && !ref_evt && state == LAG_DN) |=> state == LAG_HOLD);

    p_loc_else_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_evt && !ref_evt && state != LAG_DN) |=> state == LAG_UP);

    p_cancel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_evt && loc_evt) |=> $stable(state));

endmodule

// File: rtl/tdpll_integrate.sv
// Module: saturating signed integrator of the lead/lag state.
// On each tick the state (-1, 0, +1) is added to the accumulator, which
// clamps at its signed limits. Assumes tick is a one-cycle strobe.
module tdpll_integrate
    import tdpll_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  lag_t                    state,
    output logic signed [ACC_W-1:0] acc
);

    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    // Add the state on each tick unless that would pass a limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (tick) begin
            if (state == LAG_UP && acc != ACC_MAX) begin
                acc <= acc + 1'b1;
            end else if (state == LAG_DN && acc != ACC_MIN) begin
                acc <= acc - 1'b1;
            end
        end
    end

    p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(acc));

    p_hold_on_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == LAG_HOLD) |=> $stable(acc));

    p_sat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == LAG_UP && acc == ACC_MAX) |=> acc == ACC_MAX);

    p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == LAG_DN && acc == ACC_MIN) |=> acc == ACC_MIN);

endmodule

// File: rtl/tdpll_osc.sv
// Module: programmable local oscillator counting update ticks.
// Period = nominal + floor(acc*gain/2^GAIN_FRAC), clamped to
// [max(min,1), max(max,lo)]; the period is evaluated live on each tick.
// Assumes configuration inputs are quasi-static relative to the clock.
module tdpll_osc #(
    parameter int ACC_W     = 16,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int PER_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    input  logic signed [ACC_W-1:0] acc,
    input  logic [GAIN_W-1:0]       gain,
    input  logic [PER_W-1:0]        nom_period,
    input  logic [PER_W-1:0]        min_period,
    input  logic [PER_W-1:0]        max_period,
    output logic                    fire
);

    localparam int PW = ACC_W + GAIN_W + 1;
    localparam int SW = PW + PER_W + 2;

    logic signed [PW-1:0]    prod;
    logic signed [PW-1:0]    corr;
    logic signed [SW-1:0]    raw;
    logic [PER_W-1:0]        lo;
    logic [PER_W-1:0]        hi;
    logic [PER_W-1:0]        period;
    logic [PER_W-1:0]        cnt;
    logic                    wrap;

    // Scale the accumulator by the unsigned gain and drop fraction bits.
    always_comb begin
        prod = acc * $signed({1'b0, gain});
        corr = prod >>> GAIN_FRAC;
        raw  = $signed({{(SW-PW){corr[PW-1]}}, corr})
             + $signed({{(SW-PER_W){1'b0}}, nom_period});
    end

    // Clamp the raw period into the effective, never-zero bounds.
    always_comb begin
        lo = (min_period == '0) ? PER_W'(1) : min_period;
        hi = (max_period < lo) ? lo : max_period;
        if (raw < $signed({{(SW-PER_W){1'b0}}, lo})) begin
            period = lo;
        end else if (raw > $signed({{(SW-PER_W){1'b0}}, hi})) begin
            period = hi;
        end else begin
            period = raw[PER_W-1:0];
        end
    end

    // The count reaching the period on this tick ends the cycle.
    always_comb begin
        wrap = ({1'b0, cnt} + 1'b1) >= {1'b0, period};
    end

    // Advance the tick count and pulse once per completed period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else if (tick) begin
            cnt  <= wrap ? '0 : cnt + 1'b1;
            fire <= wrap;
        end else begin
            fire <= 1'b0;
        end
    end

    p_period_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        period != '0);

    p_fire_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> $past(tick));

    p_fire_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> cnt == '0);

endmodule

// File: rtl/tempo_dpll.sv
// Module: top of the tempo-tracking DPLL.
// Wires the tick prescaler, lead/lag detector, integrator and local
// oscillator into a loop; the oscillator pulse is the detector's local
// event. Assumes ref_stb is a single-cycle strobe in the clk domain.
module tempo_dpll
    import tdpll_pkg::*;
#(
    parameter int ACC_W     = 16,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int PER_W     = 16,
    parameter int TICK_DIV  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ref_stb,
    input  logic [GAIN_W-1:0]       gain,
    input  logic [PER_W-1:0]        nom_period,
    input  logic [PER_W-1:0]        min_period,
    input  logic [PER_W-1:0]        max_period,
    output logic                    loc_pulse,
    output logic signed [ACC_W-1:0] acc_out,
    output logic [1:0]              lag_state
);

    logic tick;
    lag_t state;
    logic fire;

    tdpll_tick #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    tdpll_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_evt (ref_stb),
        .loc_evt (fire),
        .state   (state)
    );

    tdpll_integrate #(.ACC_W(ACC_W)) u_integ (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .state (state),
        .acc   (acc_out)
    );

    tdpll_osc #(
        .ACC_W     (ACC_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .PER_W     (PER_W)
    ) u_osc (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .acc        (acc_out),
        .gain       (gain),
        .nom_period (nom_period),
        .min_period (min_period),
        .max_period (max_period),
        .fire       (fire)
    );

    // Expose the oscillator pulse and the raw state code.
    always_comb begin
        loc_pulse = fire;
        lag_state = state;
    end

    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && lag_state == 2'b00 && !loc_pulse));

endmodule

// File: tb/sim_tempo_dpll.sv
module sim_tempo_dpll;

    localparam int CLK_PERIOD = 10;
    localparam int ACC_W      = 8;
    localparam int GAIN_W     = 8;
    localparam int GF         = 4;
    localparam int PER_W      = 12;
    localparam int TD         = 2;
    localparam int AMAX       = (1 << (ACC_W - 1)) - 1;
    localparam int AMIN       = -(1 << (ACC_W - 1));

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    ref_stb = 1'b0;
    logic [GAIN_W-1:0]       gain = '0;
    logic [PER_W-1:0]        nom_period = 12'd5;
    logic [PER_W-1:0]        min_period = 12'd1;
    logic [PER_W-1:0]        max_period = 12'd1000;
    logic                    loc_pulse;
    logic signed [ACC_W-1:0] acc_out;
    logic [1:0]              lag_state;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    // reference model state, updated at each rising edge
    int  m_tc = 0;
    bit  m_tick = 1'b0;
    int  m_st = 0;
    int  m_acc = 0;
    int  m_cnt = 0;
    bit  m_fire = 1'b0;

    tempo_dpll #(
        .ACC_W(ACC_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GF),
        .PER_W(PER_W), .TICK_DIV(TD)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .gain(gain),
        .nom_period(nom_period), .min_period(min_period),
        .max_period(max_period), .loc_pulse(loc_pulse),
        .acc_out(acc_out), .lag_state(lag_state)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int exp_period(int acc, int g, int nom, int mn, int mx);
        int prod;
        int raw;
        int lo;
        int hi;
        prod = (acc * g) >>> GF;
        raw  = nom + prod;
        lo   = (mn < 1) ? 1 : mn;
        hi   = (mx < lo) ? lo : mx;
        if (raw < lo) return lo;
        if (raw > hi) return hi;
        return raw;
    endfunction

    function automatic int next_state(int st, bit r, bit l);
        if (r && !l) return (st == 1) ? 0 : -1;
        if (l && !r) return (st == -1) ? 0 : 1;
        return st;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    function automatic int st_code(int s);
        return (s == -1) ? 3 : s;
    endfunction

    // Reference model step (R5 tick, R7 oscillator, R2-R4 detector, R6 acc).
    always @(posedge clk) begin
        int per;
        int n_cnt;
        bit n_fire;
        int n_st;
        int n_acc;
        if (!rst_n) begin
            m_tc = 0; m_tick = 0; m_st = 0; m_acc = 0; m_cnt = 0; m_fire = 0;
        end else begin
            per = exp_period(m_acc, gain, nom_period, min_period, max_period);
            n_cnt = m_cnt; n_fire = 0;
            if (m_tick) begin
                if (m_cnt + 1 >= per) begin n_cnt = 0; n_fire = 1; end
                else n_cnt = m_cnt + 1;
            end
            n_st = next_state(m_st, ref_stb, m_fire);
            n_acc = m_acc;
            if (m_tick) begin
                n_acc = m_acc + m_st;
                if (n_acc > AMAX) n_acc = AMAX;
                if (n_acc < AMIN) n_acc = AMIN;
            end
            m_tick = (m_tc == TD - 1);
            m_tc = (m_tc == TD - 1) ? 0 : m_tc + 1;
            m_cnt = n_cnt; m_fire = n_fire; m_st = n_st; m_acc = n_acc;
        end
    end

    // Cycle-by-cycle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (mon_en && !done) begin
            check(lag_state == 2'(st_code(m_st)), "R1 R2 R3 R4 state", int'(lag_state), st_code(m_st));
            check(int'(acc_out) == m_acc, "R5 R6 accumulator", int'(acc_out), m_acc);
            check(loc_pulse == m_fire, "R7 local pulse", int'(loc_pulse), int'(m_fire));
        end
    end

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_pulse();
        int g;
        g = 0;
        while (!loc_pulse && g < 20000) begin @(negedge clk); g++; end
    endtask

    task automatic measure_gap(output int gap);
        wait_pulse();
        gap = 0;
        do begin @(negedge clk); gap++; end while (!loc_pulse && gap < 20000);
    endtask

    task automatic pulse_ref();
        ref_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
    endtask

    initial begin
        int gap;
        int s0;
        // R8: reset state
        repeat (3) @(negedge clk);
        check(acc_out == 0, "R8 reset acc", int'(acc_out), 0);
        check(lag_state == 2'b00, "R8 reset state", int'(lag_state), 0);
        check(loc_pulse == 1'b0, "R8 reset pulse", int'(loc_pulse), 0);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R7: gain zero, nominal 5 ticks -> 10 clocks between pulses
        measure_gap(gap);
        measure_gap(gap);
        check(gap == 5 * TD, "R7 nominal spacing", gap, 5 * TD);
        @(negedge clk);
        check(lag_state == 2'b01, "R3 local pulses raise state", int'(lag_state), 1);

        // R6: no reference -> accumulator climbs to its positive limit
        repeat (2 * TD * (AMAX + 20)) @(negedge clk);
        check(int'(acc_out) == AMAX, "R6 positive saturation", int'(acc_out), AMAX);

        // R7: gain 1.0, acc at max, nominal 100 -> clamp to max 60 ticks
        gain = 8'd16; nom_period = 12'd100; max_period = 12'd60;
        measure_gap(gap);
        measure_gap(gap);
        check(gap == 60 * TD, "R7 upper clamp", gap, 60 * TD);

        // R2: reference strobes step state down and hold at -1
        wait_pulse();
        repeat (3) @(negedge clk);
        pulse_ref();
        check(lag_state == 2'b00, "R2 ref from +1", int'(lag_state), 0);
        pulse_ref();
        check(lag_state == 2'b11, "R2 ref from 0", int'(lag_state), 3);
        pulse_ref();
        check(lag_state == 2'b11, "R2 ref holds -1", int'(lag_state), 3);

        // R4: reference coincident with local pulse cancels
        wait_pulse();
        @(negedge clk);
        wait_pulse();
        s0 = int'(lag_state);
        ref_stb = 1'b1;
        @(negedge clk);
        ref_stb = 1'b0;
        check(int'(lag_state) == s0, "R4 coincident events", int'(lag_state), s0);

        // R6: dense references drive the accumulator to its negative limit
        gain = 8'd0; nom_period = 12'd200; max_period = 12'd1000;
        for (int i = 0; i < 400; i++) begin
            pulse_ref();
            repeat (2) @(negedge clk);
        end
        check(int'(acc_out) == AMIN, "R6 negative saturation", int'(acc_out), AMIN);

        // R7: acc near -128, gain 1.0, nominal 100 -> below min 7
        gain = 8'd16; nom_period = 12'd100; min_period = 12'd7;
        measure_gap(gap);
        measure_gap(gap);
        check(gap == 7 * TD, "R7 lower clamp", gap, 7 * TD);
        min_period = 12'd0;
        measure_gap(gap);
        measure_gap(gap);
        check(gap == 1 * TD, "R7 zero min treated as one", gap, TD);

        // Random tracking phase with a mid-run reset (R8)
        min_period = 12'd4; max_period = 12'd200; nom_period = 12'd30;
        for (int blk = 0; blk < 16; blk++) begin
            int per_ref;
            gain = 8'($urandom_range(0, 64));
            per_ref = $urandom_range(40, 90);
            for (int k = 0; k < 30; k++) begin
                int jit;
                jit = $urandom_range(0, 6);
                pulse_ref();
                repeat (per_ref + jit - 3) @(negedge clk);
            end
            if (blk == 8) begin
                rst_n = 1'b0;
                @(negedge clk);
                check(acc_out == 0, "R8 mid-run reset acc", int'(acc_out), 0);
                check(lag_state == 2'b00, "R8 mid-run reset state", int'(lag_state), 0);
                rst_n = 1'b1;
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end

endmodule